// File: doc/BRIEF.md
# Serial Transmitter with Fractional Bit-Rate Divisor

This block turns bytes written by a host into asynchronous serial frames on a single output line. Software first programs a line-format register (data length, parity, stop-bit count) and two rate registers (an integer divisor and a 3-bit fractional adjustment). It then writes bytes into a one-entry holding register. The bit period in reference clocks is 16 times the integer divisor, plus 16, plus the fractional count. This gives fine rate steps without a second clock.

Each frame is a low start bit, then 5 to 8 data bits least significant first, then an optional parity bit, then one or two high stop bits. Two status outputs are provided. One shows that the holding register can accept a new byte. The other shows that the transmitter has nothing left to send. The format and rate are captured when a frame begins, so reprogramming during a frame only affects later frames. While the integer divisor is zero, the transmitter is unconfigured and keeps the line idle.

Top module: `serial_tx_fracdiv`

## Requirements
- R1: After reset, `txd` is 1, `hold_empty` is 1 and `tx_empty` is 1.
- R2: A frame starts with a low start bit. It is followed by N data bits, least significant first, where N = line-format bits [1:0] + 5 (so 5, 6, 7 or 8).
- R3: Line-format bit 2 set gives two stop bits and clear gives one. Stop bits are high, and the line is high whenever no frame is in flight.
- R4: Line-format bit 5 set inserts a parity bit right after the last data bit. Bit 3 set makes the parity even (data ones plus parity bit is even). Bit 3 clear makes it odd.
- R5: Every bit lasts 16*D + F + 16 clocks. D is the 16-bit integer divisor and F is the low 3 bits of the fractional register.
- R6: While D is zero, a written byte stays in the holding register and the line stays high. Transmission of that byte starts once a nonzero D is written.
- R7: A write to the holding register makes both `hold_empty` and `tx_empty` low after that clock edge. When the transmitter is idle and D is nonzero, the start bit begins on the next edge.
- R8: `hold_empty` goes high when the byte moves into the shifter. `tx_empty` goes high exactly (frame bits × bit period) clocks after the start bit begins, provided no byte is pending.
- R9: Format and rate are sampled at frame start. Writes to them during a frame leave the bits and timing of that frame unchanged.
- R10: A byte written while a frame is in flight starts on the edge that ends the previous last stop bit, with no idle gap. `tx_empty` stays low across the join.
- R11: Register select on `wr_sel`: 0 is the line format (`wr_data[7:0]`), 1 is the integer divisor (`wr_data[15:0]`), 2 is the fraction (`wr_data[2:0]`), and 3 is the holding register (`wr_data[7:0]`).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select |
| wr_data | input | 16 | Write data |
| txd | output | 1 | Serial output line |
| hold_empty | output | 1 | Holding register can take a byte |
| tx_empty | output | 1 | Nothing pending and nothing in flight |

## Verification
The bench samples every bit at its centre for each data length, both stop counts, and both parity senses. It also checks the exact cycle at which `tx_empty` returns. An off-by-one in the period sum or a dropped fractional term shifts that cycle, and a wrong parity sense flips the parity sample. A zero divisor is held for hundreds of cycles with a byte pending; a design that ignores it would drive a start bit. The divisor and format are rewritten mid-frame, which a design that reads them live would corrupt. A second byte queued during a frame must start right on the stop-bit boundary; a design that idles between frames would show a high sample there.

// File: rtl/serial_tx_fracdiv.sv
module serial_tx_fracdiv #(
  parameter int DIV_W   = 16,
  parameter int FRAC_W  = 3,
  parameter int MAXBITS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [DIV_W-1:0] wr_data,
  output logic             txd,
  output logic             hold_empty,
  output logic             tx_empty
);
  localparam int PER_W = DIV_W + 5;
  localparam int CNT_W = $clog2(MAXBITS + 1);

  logic [1:0]        len_q;
  logic              stop2_q, even_q, par_q;
  logic [DIV_W-1:0]  div_q;
  logic [FRAC_W-1:0] frac_q;
  logic [7:0]        hold_q;
  logic              hold_full, busy;
  logic [MAXBITS-1:0] shreg, frame;
  logic [CNT_W-1:0]  bits_left, nbits;
  logic [PER_W-1:0]  tick_cnt, per_q, period_now;
  logic              pbit, last_tick, load_now, wr_hold;

  assign wr_hold    = wr_en && wr_sel == 2'd3;
  assign period_now = PER_W'({div_q, 4'b0000}) + PER_W'(frac_q) + PER_W'(16);
  assign nbits      = CNT_W'(7) + CNT_W'(len_q) + CNT_W'(par_q) + CNT_W'(stop2_q);
  assign last_tick  = busy && tick_cnt == '0 && bits_left == CNT_W'(1);
  assign load_now   = hold_full && div_q != '0 && (!busy || last_tick);

  always_comb begin
    int dbits;
    dbits = int'(len_q) + 5;
    pbit  = !even_q;
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < dbits) begin
        frame[i+1] = hold_q[i];
        pbit = pbit ^ hold_q[i];
      end
    for (int i = 0; i < MAXBITS; i++)
      if (par_q && i == dbits + 1) frame[i] = pbit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0; stop2_q <= 1'b0; even_q <= 1'b0; par_q <= 1'b0;
      div_q <= '0; frac_q <= '0; hold_q <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: begin
          len_q <= wr_data[1:0]; stop2_q <= wr_data[2];
          even_q <= wr_data[3]; par_q <= wr_data[5];
        end
        2'd1: div_q  <= wr_data;
        2'd2: frac_q <= wr_data[FRAC_W-1:0];
        default: hold_q <= wr_data[7:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      busy      <= 1'b0;
      shreg     <= '1;
      bits_left <= '0;
      tick_cnt  <= '0;
      per_q     <= '0;
    end else begin
      if (wr_hold)       hold_full <= 1'b1;
      else if (load_now) hold_full <= 1'b0;

      if (load_now) begin
        busy      <= 1'b1;
        shreg     <= frame;
        bits_left <= nbits;
        per_q     <= period_now;
        tick_cnt  <= period_now - PER_W'(1);
      end else if (busy && tick_cnt == '0) begin
        shreg     <= {1'b1, shreg[MAXBITS-1:1]};
        bits_left <= bits_left - CNT_W'(1);
        tick_cnt  <= per_q - PER_W'(1);
        if (bits_left == CNT_W'(1)) busy <= 1'b0;
      end else if (busy) begin
        tick_cnt <= tick_cnt - PER_W'(1);
      end
    end
  end

  assign txd        = busy ? shreg[0] : 1'b1;
  assign hold_empty = !hold_full;
  assign tx_empty   = !hold_full && !busy;

  assert_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);
  assert_write_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hold |=> (!hold_empty && !tx_empty));
  assert_nodiv_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == '0 && !busy) |=> !busy);
  assert_flag_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> hold_empty);
  assert_rate_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_tick) |=> $stable(per_q));
endmodule

// File: tb/serial_tx_fracdiv_tb.sv
module serial_tx_fracdiv_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic txd, hold_empty, tx_empty;
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  serial_tx_fracdiv u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .txd(txd), .hold_empty(hold_empty), .tx_empty(tx_empty));

  always #(CLK_PERIOD/2) clk = ~clk;

  // {line format, divisor, fraction, byte}
  localparam logic [39:0] VEC [6] = '{
    {8'h03, 16'd1, 8'd0, 8'hA5},
    {8'h00, 16'd1, 8'd3, 8'hF3},
    {8'h2B, 16'd1, 8'd1, 8'h07},
    {8'h26, 16'd2, 8'd7, 8'h55},
    {8'h05, 16'd1, 8'd5, 8'h3C},
    {8'h23, 16'd1, 8'd2, 8'h00}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  function automatic int nbits_of(input logic [7:0] lc);
    return 2 + int'(lc[1:0]) + 5 + int'(lc[5]) + int'(lc[2]);
  endfunction

  function automatic logic ebit(input logic [7:0] lc, input logic [7:0] d, input int i);
    int dn = int'(lc[1:0]) + 5;
    logic ones = 1'b0;
    for (int k = 0; k < dn; k++) ones ^= d[k];
    if (i == 0) return 1'b0;
    if (i <= dn) return d[i-1];
    if (lc[5] && i == dn + 1) return lc[3] ? ones : ~ones;
    return 1'b1;
  endfunction

  // t=0 is the first negedge after the call; the start bit must be there
  task automatic check_frame(input logic [7:0] lc, input int dv, input int fr,
                             input logic [7:0] d, input bit more);
    int p = 16*dv + fr + 16;
    int nb = nbits_of(lc);
    for (int t = 0; t < nb*p; t++) begin
      @(negedge clk);
      if (t % p == p/2)
        chk(txd == ebit(lc, d, t/p), $sformatf("R2/R3/R4/R5 bit%0d lc=%h", t/p, lc),
            txd, ebit(lc, d, t/p));
      if (t == 0) chk(hold_empty == 1'b1, "R8 hold_empty at load", hold_empty, 1);
      if (t == nb*p - 1) chk(tx_empty == 1'b0, "R8 busy in last stop", tx_empty, 0);
    end
    if (!more) begin
      @(negedge clk);
      chk(tx_empty == 1'b1, "R8 tx_empty at frame end", tx_empty, 1);
      chk(txd == 1'b1, "R3 idle high after frame", txd, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int lows;
    repeat (3) @(negedge clk);
    chk(txd == 1'b1, "R1 txd reset", txd, 1);
    chk(hold_empty == 1'b1, "R1 hold_empty reset", hold_empty, 1);
    chk(tx_empty == 1'b1, "R1 tx_empty reset", tx_empty, 1);
    rst_n = 1'b1;

    // R11 register map drives all vectors
    foreach (VEC[v]) begin
      wr(2'd0, {8'h00, VEC[v][39:32]});
      wr(2'd1, VEC[v][31:16]);
      wr(2'd2, {8'h00, VEC[v][15:8]});
      wr(2'd3, {8'h00, VEC[v][7:0]});
      chk(!hold_empty && !tx_empty, "R7 flags low after write", {hold_empty, tx_empty}, 0);
      chk(txd == 1'b1, "R7 line still idle", txd, 1);
      check_frame(VEC[v][39:32], int'(VEC[v][31:16]), int'(VEC[v][10:8]), VEC[v][7:0], 0);
    end

    // R6 zero divisor holds the byte
    wr(2'd0, 16'h0003); wr(2'd2, 16'd0); wr(2'd1, 16'd0);
    wr(2'd3, 16'h005A);
    lows = 0;
    repeat (300) begin @(negedge clk); if (!txd) lows++; end
    chk(lows == 0, "R6 no output with zero divisor", lows, 0);
    chk(!tx_empty && !hold_empty, "R6 byte stays pending", {hold_empty, tx_empty}, 0);
    wr(2'd1, 16'd1);
    check_frame(8'h03, 1, 0, 8'h5A, 0);

    // R9 reprogramming mid-frame
    wr(2'd0, 16'h002B); wr(2'd1, 16'd1); wr(2'd2, 16'd2);
    wr(2'd3, 16'h0096);
    fork
      check_frame(8'h2B, 1, 2, 8'h96, 0);
      begin
        repeat (60) @(negedge clk);
        wr(2'd1, 16'd3); wr(2'd0, 16'h0004); wr(2'd2, 16'd6);
      end
    join
    chk(1'b1, "R9 frame intact after config writes", 1, 1);

    // R10 queued byte follows with no gap
    wr(2'd0, 16'h0003); wr(2'd1, 16'd1); wr(2'd2, 16'd0);
    wr(2'd3, 16'h00C3);
    fork
      check_frame(8'h03, 1, 0, 8'hC3, 1);
      wr(2'd3, 16'h0081);
    join
    check_frame(8'h03, 1, 0, 8'h81, 0);
    chk(tx_empty == 1'b1, "R10 both bytes sent", tx_empty, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule